// File: doc/BRIEF.md
# Banked Stack Pointer Slice

This block is the slice of a processor register file that holds the stack pointer register (address register 7) and its two shadow copies. One shadow belongs to user mode and the other to supervisor mode. Software reads and writes of the stack pointer always reach a single live register. That register is exchanged with the shadow bank whenever the privilege level changes.

A privilege change request names the target mode. If the target differs from the current mode, the live register is parked in the shadow of the mode being left and reloaded from the shadow of the mode being entered. A write-back command parks the live value in the current mode's shadow without any change of mode. A separate half-word load path lets the reset sequencer fill the supervisor shadow 16 bits at a time while it fetches the initial stack pointer. Both shadows are visible on output ports so that neighbouring logic can read them.

Top module: `sp_bank`

## Requirements
- R1: After reset the slice is in supervisor mode (`sup_o` = 1), and the live register and both shadows hold 0.
- R2: A write to the live register (`a7_we_i`) appears on `a7_rdata_o` in the cycle after the write edge.
- R3: A mode request whose target equals the current mode changes neither the mode, the live register nor either shadow.
- R4: A mode request whose target differs from the current mode does three things at the next edge. It stores the live value into the shadow of the old mode (index 0 = user on `usp_o`, index 1 = supervisor on `ssp_o`). It loads the live register from the shadow of the new mode. It sets `sup_o` to the target.
- R5: When a live-register write and a mode swap fall in the same cycle, the written value, not the old live value, is stored into the old mode's shadow.
- R6: A write-back command copies the live value into the current mode's shadow and leaves the mode unchanged. A same-cycle write counts as the live value.
- R7: The half-load path writes `ssp_ld_data_i` into bits 31:16 (`ssp_ld_hi_i`) and/or bits 15:0 (`ssp_ld_lo_i`) of the supervisor shadow.
- R8: In supervisor mode a half-load also writes the same half of the live register. In user mode it leaves the live register unchanged.
- R9: A half-load is ignored in any cycle that also carries a live-register write, a mode swap or a write-back.
- R10: A write-back that coincides with a mode swap has no effect beyond the swap itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a7_we_i | input | 1 | Write strobe for the live stack pointer |
| a7_wdata_i | input | 32 | Write data for the live stack pointer |
| a7_rdata_o | output | 32 | Live stack pointer value |
| mode_req_i | input | 1 | Privilege change request |
| mode_sup_i | input | 1 | Requested mode: 1 supervisor, 0 user |
| wb_i | input | 1 | Copy the live value into the current mode's shadow |
| ssp_ld_hi_i | input | 1 | Load the upper half of the supervisor shadow |
| ssp_ld_lo_i | input | 1 | Load the lower half of the supervisor shadow |
| ssp_ld_data_i | input | 16 | Half-word load data |
| sup_o | output | 1 | Current mode: 1 supervisor |
| usp_o | output | 32 | User shadow value |
| ssp_o | output | 32 | Supervisor shadow value |

## Verification
The bench goes after the collisions. In one case a write and a swap share a cycle; a design that saves the stale live value would show the old pointer on `ssp_o`. A same-mode request is also exercised, because a design that swaps without comparing modes would reload the live register from a stale shadow. Half-loads are issued in both modes and alongside a write. This catches a design that leaves the live copy stale in supervisor mode, writes it in user mode, or lets the load race the write. Round trips between modes confirm that each shadow returns the value parked in it.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } priv_mode_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/sp_bank_ctrl.sv
module sp_bank_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              sup_q_i,
  input  logic              a7_we_i,
  input  logic [DATA_W-1:0] a7_wdata_i,
  input  logic [DATA_W-1:0] a7_q_i,
  input  logic              mode_req_i,
  input  logic              mode_sup_i,
  input  logic              wb_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  output logic              swap_o,
  output logic [DATA_W-1:0] eff_o,
  output logic              save_en_o,
  output logic              save_idx_o,
  output logic              ld_hi_en_o,
  output logic              ld_lo_en_o
);
  logic busy;

  assign swap_o     = mode_req_i && (mode_sup_i != sup_q_i);
  // a same-cycle write is the value that gets parked
  assign eff_o      = a7_we_i ? a7_wdata_i : a7_q_i;
  assign save_en_o  = swap_o || wb_i;
  assign save_idx_o = sup_q_i;
  assign busy       = a7_we_i || swap_o || wb_i;
  assign ld_hi_en_o = ld_hi_i && !busy;
  assign ld_lo_en_o = ld_lo_i && !busy;
endmodule

// File: rtl/sp_bank_store.sv
module sp_bank_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBANK  = sp_bank_pkg::NUM_BANKS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         save_en_i,
  input  logic                         save_idx_i,
  input  logic [DATA_W-1:0]            save_data_i,
  input  logic                         ld_hi_i,
  input  logic                         ld_lo_i,
  input  logic [DATA_W/2-1:0]          ld_data_i,
  output logic [NBANK-1:0][DATA_W-1:0] bank_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (save_en_i && (int'(save_idx_i) == g)) begin
        q <= save_data_i;
      end else if (g == int'(sp_bank_pkg::MODE_SUP)) begin
        if (ld_hi_i) q[DATA_W-1:HALF_W] <= ld_data_i;
        if (ld_lo_i) q[HALF_W-1:0]      <= ld_data_i;
      end
    end
    assign bank_o[g] = q;
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a7_we_i,
  input  logic [DATA_W-1:0] a7_wdata_i,
  output logic [DATA_W-1:0] a7_rdata_o,
  input  logic              mode_req_i,
  input  logic              mode_sup_i,
  input  logic              wb_i,
  input  logic              ssp_ld_hi_i,
  input  logic              ssp_ld_lo_i,
  input  logic [HALF_W-1:0] ssp_ld_data_i,
  output logic              sup_o,
  output logic [DATA_W-1:0] usp_o,
  output logic [DATA_W-1:0] ssp_o
);
  import sp_bank_pkg::*;

  logic                            sup_q;
  logic [DATA_W-1:0]               a7_q, a7_d, eff;
  logic                            swap, save_en, save_idx, ld_hi_en, ld_lo_en;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank;

  sp_bank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .sup_q_i   (sup_q),
    .a7_we_i   (a7_we_i),
    .a7_wdata_i(a7_wdata_i),
    .a7_q_i    (a7_q),
    .mode_req_i(mode_req_i),
    .mode_sup_i(mode_sup_i),
    .wb_i      (wb_i),
    .ld_hi_i   (ssp_ld_hi_i),
    .ld_lo_i   (ssp_ld_lo_i),
    .swap_o    (swap),
    .eff_o     (eff),
    .save_en_o (save_en),
    .save_idx_o(save_idx),
    .ld_hi_en_o(ld_hi_en),
    .ld_lo_en_o(ld_lo_en)
  );

  sp_bank_store #(.DATA_W(DATA_W), .NBANK(NUM_BANKS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_en_i  (save_en),
    .save_idx_i (save_idx),
    .save_data_i(eff),
    .ld_hi_i    (ld_hi_en),
    .ld_lo_i    (ld_lo_en),
    .ld_data_i  (ssp_ld_data_i),
    .bank_o     (bank)
  );

  always_comb begin
    a7_d = eff;
    if (swap) begin
      a7_d = bank[mode_sup_i];
    end else if (sup_q == MODE_SUP) begin
      // live copy tracks the supervisor shadow during half-loads
      if (ld_hi_en) a7_d[DATA_W-1:HALF_W] = ssp_ld_data_i;
      if (ld_lo_en) a7_d[HALF_W-1:0]      = ssp_ld_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_q <= MODE_SUP;
      a7_q  <= '0;
    end else begin
      a7_q <= a7_d;
      if (swap) sup_q <= mode_sup_i;
    end
  end

  assign a7_rdata_o = a7_q;
  assign sup_o      = sup_q;
  assign usp_o      = bank[MODE_USER];
  assign ssp_o      = bank[MODE_SUP];

  a_r3_same_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && mode_sup_i == sup_o && !a7_we_i && !wb_i && !ssp_ld_hi_i && !ssp_ld_lo_i)
    |=> ($stable(a7_rdata_o) && $stable(sup_o) && $stable(usp_o) && $stable(ssp_o)));

  a_r4_mode_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_i |=> (sup_o == $past(mode_sup_i)));

  a_r4_enter_user_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && !mode_sup_i && sup_o) |=> (a7_rdata_o == $past(usp_o)));

  a_r4_enter_sup_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && mode_sup_i && !sup_o) |=> (a7_rdata_o == $past(ssp_o)));

  a_r5_leave_sup_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && !mode_sup_i && sup_o)
    |=> (ssp_o == (($past(a7_we_i)) ? $past(a7_wdata_i) : $past(a7_rdata_o))));

  a_r6_wb_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_i && !mode_req_i) |=> $stable(sup_o));

  a_r9_user_load_keeps_a7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_o && !a7_we_i && !mode_req_i) |=> $stable(a7_rdata_o));
endmodule

// File: tb/tb_sp_bank.sv
module tb_sp_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a7_we = 1'b0;
  logic [31:0] a7_wdata = '0;
  logic [31:0] a7_rdata;
  logic        mode_req = 1'b0;
  logic        mode_sup = 1'b0;
  logic        wb = 1'b0;
  logic        ld_hi = 1'b0;
  logic        ld_lo = 1'b0;
  logic [15:0] ld_data = '0;
  logic        sup;
  logic [31:0] usp, ssp;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sp_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a7_we_i(a7_we), .a7_wdata_i(a7_wdata), .a7_rdata_o(a7_rdata),
    .mode_req_i(mode_req), .mode_sup_i(mode_sup), .wb_i(wb),
    .ssp_ld_hi_i(ld_hi), .ssp_ld_lo_i(ld_lo), .ssp_ld_data_i(ld_data),
    .sup_o(sup), .usp_o(usp), .ssp_o(ssp)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, sample 1 ns later
  task automatic step(logic we, logic [31:0] wd, logic req, logic ms, logic w,
                      logic hi, logic lo, logic [15:0] d);
    @(negedge clk);
    a7_we = we; a7_wdata = wd; mode_req = req; mode_sup = ms; wb = w;
    ld_hi = hi; ld_lo = lo; ld_data = d;
    @(posedge clk);
    #1;
    a7_we = 0; mode_req = 0; wb = 0; ld_hi = 0; ld_lo = 0;
  endtask

  task automatic t_reset;
    check("R1 sup", {31'd0, sup}, 32'd1);
    check("R1 a7", a7_rdata, 32'd0);
    check("R1 usp", usp, 32'd0);
    check("R1 ssp", ssp, 32'd0);
  endtask

  task automatic t_write;
    step(1, 32'hCAFE_0010, 0, 0, 0, 0, 0, 16'h0);
    check("R2 write", a7_rdata, 32'hCAFE_0010);
  endtask

  task automatic t_sup_load;
    step(0, 0, 0, 0, 0, 1, 0, 16'h1234);
    check("R8 hi a7", a7_rdata, 32'h1234_0010);
    check("R7 hi ssp", ssp, 32'h1234_0000);
    step(0, 0, 0, 0, 0, 0, 1, 16'h5678);
    check("R8 lo a7", a7_rdata, 32'h1234_5678);
    check("R7 lo ssp", ssp, 32'h1234_5678);
  endtask

  task automatic t_swaps;
    step(0, 0, 1, 0, 0, 0, 0, 16'h0);
    check("R4 sup_o user", {31'd0, sup}, 32'd0);
    check("R4 a7 from usp", a7_rdata, 32'd0);
    check("R4 ssp saved", ssp, 32'h1234_5678);
    step(1, 32'hAAAA_0001, 0, 0, 0, 0, 0, 16'h0);
    step(0, 0, 1, 1, 0, 0, 0, 16'h0);
    check("R4 a7 from ssp", a7_rdata, 32'h1234_5678);
    check("R4 usp saved", usp, 32'hAAAA_0001);
    check("R4 sup_o sup", {31'd0, sup}, 32'd1);
  endtask

  task automatic t_same_mode;
    step(0, 0, 1, 1, 0, 0, 0, 16'h0);
    check("R3 a7", a7_rdata, 32'h1234_5678);
    check("R3 sup_o", {31'd0, sup}, 32'd1);
    check("R3 usp", usp, 32'hAAAA_0001);
  endtask

  task automatic t_swap_write;
    step(1, 32'h0BAD_F00D, 1, 0, 0, 0, 0, 16'h0);
    check("R5 ssp gets write", ssp, 32'h0BAD_F00D);
    check("R5 a7 from usp", a7_rdata, 32'hAAAA_0001);
  endtask

  task automatic t_wb;
    step(1, 32'h0000_5555, 0, 0, 0, 0, 0, 16'h0);
    check("R6 usp before wb", usp, 32'hAAAA_0001);
    step(0, 0, 0, 0, 1, 0, 0, 16'h0);
    check("R6 usp after wb", usp, 32'h0000_5555);
    check("R6 mode kept", {31'd0, sup}, 32'd0);
    step(1, 32'h0000_7777, 0, 0, 1, 0, 0, 16'h0);
    check("R6 wb same-cycle write", usp, 32'h0000_7777);
  endtask

  task automatic t_user_load;
    step(0, 0, 0, 0, 0, 1, 1, 16'h4242);
    check("R8 user a7 kept", a7_rdata, 32'h0000_7777);
    check("R7 both halves", ssp, 32'h4242_4242);
  endtask

  task automatic t_load_blocked;
    step(1, 32'h0000_9999, 0, 0, 0, 1, 0, 16'h1111);
    check("R9 load vs write ssp", ssp, 32'h4242_4242);
    step(0, 0, 0, 0, 1, 0, 1, 16'h2222);
    check("R9 load vs wb ssp", ssp, 32'h4242_4242);
    step(0, 0, 1, 1, 1, 0, 0, 16'h0);
    check("R10 swap+wb usp", usp, 32'h0000_9999);
    check("R10 swap+wb a7", a7_rdata, 32'h4242_4242);
    check("R10 swap+wb ssp", ssp, 32'h4242_4242);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_write;
    t_sup_load;
    t_swaps;
    t_same_mode;
    t_swap_write;
    t_wb;
    t_user_load;
    t_load_blocked;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule